// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the register window that a host processor sees when it talks to a 16-bit graphics coprocessor. The host reaches it over an 8-bit bus with a 10-bit byte offset covering 768 bytes. The window holds sixteen 16-bit general registers, a status flag register, a set of byte-wide bank, configuration, screen, clock and mode registers, a cache base register and a 512-byte cache RAM. Every host access is decoded here. Read-only and reserved bits are masked off before storage or on read-back.

Two accesses have side effects. A host write to the high byte of general register 15 starts the coprocessor by setting the go flag. A host read of the status high byte clears the pending interrupt flag. The execution core sees a minimal control port. It gets a go level and a fast-multiply select. It can end a run with a one-cycle stop strobe, and a companion line on that strobe raises the interrupt.

Host requests travel on a single valid strobe with a write qualifier. The block accepts one request on every cycle that valid is high and never applies back-pressure. The host must therefore present at most one access per cycle. Read data returns with its own valid one cycle after the request, and the host must take it in that cycle.

Top module: `gfx_host_regs`

## Requirements
- R1: The general registers occupy offsets 0x000 to 0x01F, two bytes each, with the low byte at the even offset. Host writes are stored per byte and read back unchanged while go is clear.
- R2: A host write to offset 0x01F while go is clear sets go. go_o then goes high, and status low byte 0x030 bit 5 reads 1.
- R3: While go is set, host writes to offsets 0x000 to 0x01F have no effect. This includes a second write to 0x01F.
- R4: A core_stop pulse while go is set clears go. If core_irq is high with it, the pulse also sets the interrupt flag, which reads as status high byte 0x031 bit 7. A core_stop pulse while go is clear has no effect.
- R5: A host read of 0x031 returns the value before the read and then clears the interrupt flag. If a raising core_stop arrives in the same cycle, the flag ends up set.
- R6: Configuration byte 0x037 keeps only bits 7 and 5. Bit 7 masks irq_o, which otherwise follows the interrupt flag, but it does not mask the flag itself. Bit 5 drives fast_mul_o.
- R7: The cache base register sits at 0x03E (low) and 0x03F (high). Bits 3..0 of the low byte always read 0.
- R8: Offset 0x03B reads the VERSION parameter, and host writes to it have no effect.
- R9: Offsets 0x100 to 0x2FF map a 512-byte cache RAM with byte read and write.
- R10: Offsets 0x020-0x02F, 0x032, 0x035, 0x03D and 0x040-0x0FF read 0, and writes to them are ignored.
- R11: The byte registers keep only their defined bits. 0x033 keeps bit 0, and 0x039 keeps bit 0. 0x034, 0x036 and 0x038 keep all 8 bits. 0x03A keeps bits 5..0, and 0x03C keeps bits RAM_BANK_W-1..0 (default 2).
- R12: The host may write only the flag bits of the status register. For 0x030 the write mask is 0x5E, and for 0x031 it is 0x1F. go (0x030 bit 5) and the interrupt flag (0x031 bit 7) cannot be written by the host.
- R13: A read request produces hst_rvalid with its data exactly one cycle later. A write request produces no hst_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host request strobe, one access per cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 10 | Byte offset in the window |
| hst_wdata | input | 8 | Write data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read |
| hst_rdata | output | 8 | Read data |
| core_stop | input | 1 | One-cycle stop strobe from the core |
| core_irq | input | 1 | Raise the interrupt with this stop |
| go_o | output | 1 | Coprocessor running |
| irq_o | output | 1 | Unmasked interrupt request to the host |
| fast_mul_o | output | 1 | High-speed multiply select |

## Verification
The assertions assume that core_stop is a single-cycle pulse. They also assume that the host drives valid, write and address as clean levels that are stable across each clock edge, and that it never waits on read data, because no back-pressure exists. The interrupt-origin property also assumes that irq_o can rise only from a core raise or from a write that clears the mask. The bench follows these assumptions by driving every input on the falling edge and holding each request for exactly one cycle. It pulses core_stop for one cycle only, and it pairs simultaneous host and core events explicitly so that the R5 collision is tested on purpose.

// File: rtl/ghr_pkg.sv
package ghr_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int NUM_GPR = 16;

  localparam logic [ADDR_W-1:0] OFS_STAT_LO = 10'h030;
  localparam logic [ADDR_W-1:0] OFS_STAT_HI = 10'h031;
  localparam logic [ADDR_W-1:0] OFS_BRAM    = 10'h033;
  localparam logic [ADDR_W-1:0] OFS_PBANK   = 10'h034;
  localparam logic [ADDR_W-1:0] OFS_RBANK   = 10'h036;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 10'h037;
  localparam logic [ADDR_W-1:0] OFS_SCRB    = 10'h038;
  localparam logic [ADDR_W-1:0] OFS_CLK     = 10'h039;
  localparam logic [ADDR_W-1:0] OFS_SMODE   = 10'h03A;
  localparam logic [ADDR_W-1:0] OFS_VER     = 10'h03B;
  localparam logic [ADDR_W-1:0] OFS_MBANK   = 10'h03C;
  localparam logic [ADDR_W-1:0] OFS_CB_LO   = 10'h03E;
  localparam logic [ADDR_W-1:0] OFS_CB_HI   = 10'h03F;
  localparam logic [ADDR_W-1:0] GPR_END     = 10'h020;
  localparam logic [ADDR_W-1:0] CACHE_LO    = 10'h100;
  localparam logic [ADDR_W-1:0] CACHE_END   = 10'h300;

  // Host-writable masks and read-back masks
  localparam logic [7:0] STAT_LO_WMASK = 8'h5E;
  localparam logic [7:0] STAT_HI_WMASK = 8'h1F;
  localparam logic [7:0] CFG_MASK      = 8'hA0;
  localparam logic [7:0] SMODE_MASK    = 8'h3F;
  localparam int GO_BIT       = 5;
  localparam int IRQ_BIT_HI   = 7;
  localparam int CFG_IRQ_MASK = 7;
  localparam int CFG_FAST_MUL = 5;

  typedef enum logic [3:0] {
    RG_NONE, RG_GPR, RG_STAT_LO, RG_STAT_HI, RG_BRAM, RG_PBANK,
    RG_RBANK, RG_CFG, RG_SCRB, RG_CLK, RG_SMODE, RG_VER, RG_MBANK,
    RG_CB_LO, RG_CB_HI, RG_CACHE
  } region_e;

endpackage

// File: rtl/ghr_decode.sv
module ghr_decode
  import ghr_pkg::*;
#(
  parameter int CACHE_AW = 9
) (
  input  logic [ADDR_W-1:0]   addr,
  output region_e             region,
  output logic [3:0]          gpr_idx,
  output logic                gpr_hi,
  output logic [CACHE_AW-1:0] cache_off
);

  assign gpr_idx   = addr[4:1];
  assign gpr_hi    = addr[0];
  assign cache_off = CACHE_AW'(addr[CACHE_AW-1:0] - CACHE_AW'(CACHE_LO));

  always_comb begin
    region = RG_NONE;
    if (addr < GPR_END) begin
      region = RG_GPR;
    end else if (addr >= CACHE_LO && addr < CACHE_END) begin
      region = RG_CACHE;
    end else begin
      unique case (addr)
        OFS_STAT_LO: region = RG_STAT_LO;
        OFS_STAT_HI: region = RG_STAT_HI;
        OFS_BRAM:    region = RG_BRAM;
        OFS_PBANK:   region = RG_PBANK;
        OFS_RBANK:   region = RG_RBANK;
        OFS_CFG:     region = RG_CFG;
        OFS_SCRB:    region = RG_SCRB;
        OFS_CLK:     region = RG_CLK;
        OFS_SMODE:   region = RG_SMODE;
        OFS_VER:     region = RG_VER;
        OFS_MBANK:   region = RG_MBANK;
        OFS_CB_LO:   region = RG_CB_LO;
        OFS_CB_HI:   region = RG_CB_HI;
        default:     region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ghr_gpr_file.sv
module ghr_gpr_file
  import ghr_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        idx,
  input  logic              hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int BYTES = REG_W / DATA_W;

  logic [REG_W-1:0] regs [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs[g][b*DATA_W +: DATA_W] <= '0;
        end else if (wr_en && idx == 4'(g) && int'(hi) == b) begin
          regs[g][b*DATA_W +: DATA_W] <= wdata;
        end
      end
    end
  end

  assign rd_byte = hi ? regs[idx][REG_W-1 -: DATA_W] : regs[idx][DATA_W-1:0];

endmodule

// File: rtl/ghr_ctrl_regs.sv
module ghr_ctrl_regs
  import ghr_pkg::*;
#(
  parameter logic [7:0] VERSION    = 8'h04,
  parameter int         RAM_BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  region_e           region,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pc_hit,
  input  logic              core_stop,
  input  logic              core_irq,
  output logic [DATA_W-1:0] rd_byte,
  output logic              go,
  output logic              irq_o,
  output logic              fast_mul_o
);

  logic [7:0]            stat_lo_q, stat_hi_q, cfg_q;
  logic                  bram_q, clk_q;
  logic [7:0]            pbank_q, rbank_q, scrb_q, cb_hi_q;
  logic [5:0]            smode_q;
  logic [RAM_BANK_W-1:0] mbank_q;
  logic [3:0]            cb_lo_q;
  logic                  irq_q;
  logic                  raise;

  assign raise = core_stop && go && core_irq;

  // Run control: a start only happens while idle, a stop only while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0;
    end else if (pc_hit && !go) begin
      go <= 1'b1;
    end else if (core_stop) begin
      go <= 1'b0;
    end
  end

  // Interrupt flag: a new raise wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (raise) begin
      irq_q <= 1'b1;
    end else if (rd_en && region == RG_STAT_HI) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_lo_q <= '0;
      stat_hi_q <= '0;
      cfg_q     <= '0;
      bram_q    <= 1'b0;
      clk_q     <= 1'b0;
      pbank_q   <= '0;
      rbank_q   <= '0;
      scrb_q    <= '0;
      smode_q   <= '0;
      mbank_q   <= '0;
      cb_lo_q   <= '0;
      cb_hi_q   <= '0;
    end else if (wr_en) begin
      unique case (region)
        RG_STAT_LO: stat_lo_q <= wdata & STAT_LO_WMASK;
        RG_STAT_HI: stat_hi_q <= wdata & STAT_HI_WMASK;
        RG_CFG:     cfg_q     <= wdata & CFG_MASK;
        RG_BRAM:    bram_q    <= wdata[0];
        RG_CLK:     clk_q     <= wdata[0];
        RG_PBANK:   pbank_q   <= wdata;
        RG_RBANK:   rbank_q   <= wdata;
        RG_SCRB:    scrb_q    <= wdata;
        RG_SMODE:   smode_q   <= wdata[5:0] & SMODE_MASK[5:0];
        RG_MBANK:   mbank_q   <= wdata[RAM_BANK_W-1:0];
        RG_CB_LO:   cb_lo_q   <= wdata[7:4];
        RG_CB_HI:   cb_hi_q   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = '0;
    unique case (region)
      RG_STAT_LO: begin
        rd_byte         = stat_lo_q;
        rd_byte[GO_BIT] = go;
      end
      RG_STAT_HI: begin
        rd_byte             = stat_hi_q;
        rd_byte[IRQ_BIT_HI] = irq_q;
      end
      RG_CFG:   rd_byte = cfg_q;
      RG_BRAM:  rd_byte = {7'b0, bram_q};
      RG_CLK:   rd_byte = {7'b0, clk_q};
      RG_PBANK: rd_byte = pbank_q;
      RG_RBANK: rd_byte = rbank_q;
      RG_SCRB:  rd_byte = scrb_q;
      RG_SMODE: rd_byte = {2'b0, smode_q};
      RG_VER:   rd_byte = VERSION;
      RG_MBANK: rd_byte = 8'(mbank_q);
      RG_CB_LO: rd_byte = {cb_lo_q, 4'b0};
      RG_CB_HI: rd_byte = cb_hi_q;
      default:  rd_byte = '0;
    endcase
  end

  assign irq_o      = irq_q && !cfg_q[CFG_IRQ_MASK];
  assign fast_mul_o = cfg_q[CFG_FAST_MUL];

endmodule

// File: rtl/ghr_cache_ram.sv
module ghr_cache_ram
  import ghr_pkg::*;
#(
  parameter int BYTES = 512,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte
);

  logic [DATA_W-1:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rd_byte = mem[addr];

endmodule

// File: rtl/gfx_host_regs.sv
module gfx_host_regs
  import ghr_pkg::*;
#(
  parameter logic [7:0] VERSION     = 8'h04,
  parameter int         RAM_BANK_W  = 2,
  parameter int         CACHE_BYTES = 512,
  localparam int        CACHE_AW    = $clog2(CACHE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic              hst_rvalid,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic              core_stop,
  input  logic              core_irq,
  output logic              go_o,
  output logic              irq_o,
  output logic              fast_mul_o
);

  region_e             region;
  logic [3:0]          gpr_idx;
  logic                gpr_hi;
  logic [CACHE_AW-1:0] cache_off;
  logic                wr_en, rd_en, go;
  logic [DATA_W-1:0]   gpr_rd, ctrl_rd, cache_rd, rd_mux;
  logic                pc_hit;

  assign wr_en  = hst_valid && hst_write;
  assign rd_en  = hst_valid && !hst_write;
  assign pc_hit = wr_en && region == RG_GPR && gpr_idx == 4'(NUM_GPR - 1) && gpr_hi;

  ghr_decode #(.CACHE_AW(CACHE_AW)) decode_i (
    .addr      (hst_addr),
    .region    (region),
    .gpr_idx   (gpr_idx),
    .gpr_hi    (gpr_hi),
    .cache_off (cache_off)
  );

  ghr_gpr_file #(.REG_W(16)) gpr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && region == RG_GPR && !go),
    .idx     (gpr_idx),
    .hi      (gpr_hi),
    .wdata   (hst_wdata),
    .rd_byte (gpr_rd)
  );

  ghr_ctrl_regs #(.VERSION(VERSION), .RAM_BANK_W(RAM_BANK_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .region     (region),
    .wdata      (hst_wdata),
    .pc_hit     (pc_hit),
    .core_stop  (core_stop),
    .core_irq   (core_irq),
    .rd_byte    (ctrl_rd),
    .go         (go),
    .irq_o      (irq_o),
    .fast_mul_o (fast_mul_o)
  );

  ghr_cache_ram #(.BYTES(CACHE_BYTES)) cache_i (
    .clk     (clk),
    .wr_en   (wr_en && region == RG_CACHE),
    .addr    (cache_off),
    .wdata   (hst_wdata),
    .rd_byte (cache_rd)
  );

  always_comb begin
    unique case (region)
      RG_GPR:   rd_mux = gpr_rd;
      RG_CACHE: rd_mux = cache_rd;
      RG_NONE:  rd_mux = '0;
      default:  rd_mux = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_rvalid <= rd_en;
      if (rd_en) begin
        hst_rdata <= rd_mux;
      end
    end
  end

  assign go_o = go;

endmodule

// File: rtl/gfx_host_regs_chk.sv
module gfx_host_regs_chk #(
  parameter logic [7:0] VERSION = 8'h04
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hst_valid,
  input logic       hst_write,
  input logic [9:0] hst_addr,
  input logic       hst_rvalid,
  input logic [7:0] hst_rdata,
  input logic       core_stop,
  input logic       core_irq,
  input logic       go_o,
  input logic       irq_o
);

  logic rd_req, wr_req, cfg_wr, raise;
  assign rd_req = hst_valid && !hst_write;
  assign wr_req = hst_valid && hst_write;
  assign cfg_wr = wr_req && hst_addr == 10'h037;
  assign raise  = core_stop && core_irq && go_o;

  a_r2_pc_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && hst_addr == 10'h01F && !go_o |=> go_o);

  a_r4_stop_clears_go: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop && go_o |=> !go_o);

  a_r5_irq_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) && !$past(cfg_wr) |-> $past(raise));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && hst_addr == 10'h031 && !raise |=> !irq_o);

  a_r8_version_ro: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && hst_addr == 10'h03B |=> hst_rdata == VERSION);

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && hst_addr >= 10'h040 && hst_addr < 10'h100 |=> hst_rdata == 8'h00);

  a_r13_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> hst_rvalid);

  a_r13_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !hst_rvalid);

endmodule

bind gfx_host_regs gfx_host_regs_chk #(.VERSION(VERSION)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_valid  (hst_valid),
  .hst_write  (hst_write),
  .hst_addr   (hst_addr),
  .hst_rvalid (hst_rvalid),
  .hst_rdata  (hst_rdata),
  .core_stop  (core_stop),
  .core_irq   (core_irq),
  .go_o       (go_o),
  .irq_o      (irq_o)
);

// File: tb/gfx_host_regs_tb_top.sv
module gfx_host_regs_tb_top;

  localparam logic [7:0] VER = 8'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_valid = 1'b0, hst_write = 1'b0;
  logic [9:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic       hst_rvalid;
  logic [7:0] hst_rdata;
  logic       core_stop = 1'b0, core_irq = 1'b0;
  logic       go_o, irq_o, fast_mul_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gfx_host_regs #(.VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rvalid(hst_rvalid),
    .hst_rdata(hst_rdata), .core_stop(core_stop), .core_irq(core_irq),
    .go_o(go_o), .irq_o(irq_o), .fast_mul_o(fast_mul_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_valid = 1'b0; hst_write = 1'b0;
    chk("R13 no rvalid after write", int'(hst_rvalid), 0);
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b0; hst_addr = a;
    @(negedge clk);
    hst_valid = 1'b0;
    chk("R13 rvalid after read", int'(hst_rvalid), 1);
    d = hst_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, int'(d), int'(exp));
  endtask

  task automatic stop_pulse(input logic with_irq);
    @(negedge clk);
    core_stop = 1'b1; core_irq = with_irq;
    @(negedge clk);
    core_stop = 1'b0; core_irq = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 go low after reset", int'(go_o), 0);
    chk("R6 irq_o low after reset", int'(irq_o), 0);
    rd_chk("R1 gpr reset zero", 10'h000, 8'h00);
    rd_chk("R12 status low reset", 10'h030, 8'h00);
  endtask

  task automatic t_gpr;
    wr(10'h004, 8'h34); wr(10'h005, 8'h12);
    wr(10'h01C, 8'hCD); wr(10'h01D, 8'hAB);
    rd_chk("R1 gpr2 low", 10'h004, 8'h34);
    rd_chk("R1 gpr2 high", 10'h005, 8'h12);
    rd_chk("R1 gpr14 low", 10'h01C, 8'hCD);
    rd_chk("R1 gpr14 high", 10'h01D, 8'hAB);
  endtask

  task automatic t_status_write;
    wr(10'h030, 8'hFF);
    rd_chk("R12 status low mask", 10'h030, 8'h5E);
    wr(10'h031, 8'hFF);
    rd_chk("R12 status high mask", 10'h031, 8'h1F);
    chk("R12 go not host writable", int'(go_o), 0);
    wr(10'h030, 8'h00); wr(10'h031, 8'h00);
    rd_chk("R12 status low cleared", 10'h030, 8'h00);
  endtask

  task automatic t_start_stop;
    stop_pulse(1'b1);
    rd_chk("R4 stop ignored while idle", 10'h031, 8'h00);
    wr(10'h01E, 8'h00);
    chk("R2 low pc byte no start", int'(go_o), 0);
    wr(10'h01F, 8'h80);
    chk("R2 go after pc high write", int'(go_o), 1);
    rd_chk("R2 status go bit", 10'h030, 8'h20);
    wr(10'h004, 8'h99); wr(10'h01F, 8'h11);
    rd_chk("R3 gpr write blocked", 10'h004, 8'h34);
    rd_chk("R3 pc write blocked", 10'h01F, 8'h80);
    stop_pulse(1'b0);
    chk("R4 stop clears go", int'(go_o), 0);
    chk("R4 plain stop no irq", int'(irq_o), 0);
    wr(10'h01F, 8'h81);
    stop_pulse(1'b1);
    chk("R4 stop clears go with irq", int'(go_o), 0);
    chk("R4 irq_o raised", int'(irq_o), 1);
    rd_chk("R5 read sees irq flag", 10'h031, 8'h80);
    chk("R5 irq_o cleared by read", int'(irq_o), 0);
    rd_chk("R5 flag cleared", 10'h031, 8'h00);
  endtask

  task automatic t_collision;
    wr(10'h01F, 8'h01);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = 1'b0; hst_addr = 10'h031;
    core_stop = 1'b1; core_irq = 1'b1;
    @(negedge clk);
    hst_valid = 1'b0; core_stop = 1'b0; core_irq = 1'b0;
    chk("R5 collision returns old", int'(hst_rdata), 0);
    chk("R5 raise wins over clear", int'(irq_o), 1);
    rd_chk("R5 flag still set", 10'h031, 8'h80);
  endtask

  task automatic t_cfg;
    wr(10'h01F, 8'h02);
    stop_pulse(1'b1);
    wr(10'h037, 8'hFF);
    rd_chk("R6 cfg mask", 10'h037, 8'hA0);
    chk("R6 fast_mul set", int'(fast_mul_o), 1);
    chk("R6 irq masked", int'(irq_o), 0);
    rd_chk("R6 flag unaffected by mask", 10'h031, 8'h80);
    wr(10'h01F, 8'h03);
    stop_pulse(1'b1);
    wr(10'h037, 8'h00);
    chk("R6 irq unmasked", int'(irq_o), 1);
    chk("R6 fast_mul clear", int'(fast_mul_o), 0);
    rd_chk("R5 clear again", 10'h031, 8'h80);
  endtask

  task automatic t_bytes;
    wr(10'h03E, 8'hFF); wr(10'h03F, 8'hAB);
    rd_chk("R7 cache base low", 10'h03E, 8'hF0);
    rd_chk("R7 cache base high", 10'h03F, 8'hAB);
    rd_chk("R8 version", 10'h03B, VER);
    wr(10'h03B, 8'h55);
    rd_chk("R8 version after write", 10'h03B, VER);
    wr(10'h033, 8'hFF); rd_chk("R11 backup enable", 10'h033, 8'h01);
    wr(10'h039, 8'hFF); rd_chk("R11 clock", 10'h039, 8'h01);
    wr(10'h03A, 8'hFF); rd_chk("R11 screen mode", 10'h03A, 8'h3F);
    wr(10'h03C, 8'hFF); rd_chk("R11 ram bank", 10'h03C, 8'h03);
    wr(10'h034, 8'h5A); rd_chk("R11 program bank", 10'h034, 8'h5A);
    wr(10'h036, 8'hC3); rd_chk("R11 rom bank", 10'h036, 8'hC3);
    wr(10'h038, 8'h7E); rd_chk("R11 screen base", 10'h038, 8'h7E);
  endtask

  task automatic t_cache_unused;
    wr(10'h100, 8'h11); wr(10'h1FF, 8'h22); wr(10'h200, 8'h33); wr(10'h2FF, 8'h44);
    rd_chk("R9 cache first", 10'h100, 8'h11);
    rd_chk("R9 cache 0x1ff", 10'h1FF, 8'h22);
    rd_chk("R9 cache 0x200", 10'h200, 8'h33);
    rd_chk("R9 cache last", 10'h2FF, 8'h44);
    wr(10'h020, 8'hFF); wr(10'h032, 8'hFF); wr(10'h035, 8'hFF);
    wr(10'h03D, 8'hFF); wr(10'h040, 8'hFF); wr(10'h0FF, 8'hFF);
    rd_chk("R10 unused 0x020", 10'h020, 8'h00);
    rd_chk("R10 unused 0x032", 10'h032, 8'h00);
    rd_chk("R10 unused 0x035", 10'h035, 8'h00);
    rd_chk("R10 unused 0x03d", 10'h03D, 8'h00);
    rd_chk("R10 unused 0x040", 10'h040, 8'h00);
    rd_chk("R10 unused 0x0ff", 10'h0FF, 8'h00);
    rd_chk("R10 neighbour gpr intact", 10'h01C, 8'hCD);
    rd_chk("R10 cache intact", 10'h100, 8'h11);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gpr();
    t_status_write();
    t_start_stop();
    t_collision();
    t_cfg();
    t_bytes();
    t_cache_unused();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule